// File: doc/BRIEF.md
# Voted Branch Clock Gate

This block gates one source clock onto one output branch clock under register control. The branch has two independent ways to be turned on. Software can set a local enable in the branch's own control word, or any agent can set this branch's bit in a shared vote word. The branch runs while either request is present and stops when both are gone.

The control word also reports whether the branch is really running. A read-only "off" flag in the top bit follows the actual state of the gate, brought back into the register clock domain through a synchroniser. Software can therefore poll it after turning the branch on or off. While the branch runs, the top nibble also shows whether a network-on-chip handshake input is active. The gate opens and closes only while the source clock is low, so the branch never emits a shortened high pulse.

The register port is a plain single-cycle write strobe with a one-bit address and a combinational read. Address 0 selects the control word and address 1 selects the vote word. The `noc_hs` input is taken as synchronous to the register clock.

Top module: `vbg_branch_gate`

## Requirements
- R1: Writing 1 to bit 0 of the control word (address 0) turns the branch on, and `clk_out` then toggles with `src_clk`. Bit 0 reads back the value written.
- R2: Bit 31 of the control word (the off flag) reads 1 whenever the branch is not running. After a request turns the branch on, bit 31 still reads 1 in the cycle right after the write. It reads 0 between 2 and 10 register clock cycles after the write edge, and it stays 0 while the request stays present.
- R3: The vote word (address 1) stores and reads back VOTE_W bits. Its bit VOTE_IDX (3 by default) alone turns the branch on with the local enable at 0. Its other bits have no effect on the branch.
- R4: While the branch runs and `noc_hs` is 0, bits 31:28 of the control word read 4'b0000.
- R5: While the branch runs and `noc_hs` is 1, bits 31:28 read 4'b0010 (bit 29 set). While the branch is off, they read 4'b1000 whatever the value of `noc_hs`.
- R6: When both requests are removed, the off flag returns to 1 only after `clk_out` has stopped. From the time it reads 1, `clk_out` stays low with no edges.
- R7: Every high pulse on `clk_out` lasts a full high phase of `src_clk`.
- R8: Writes to bits 31:1 of the control word are ignored. Bits 30, 28 and 27:1 always read 0, and bits 31 and 29 show only the branch status.
- R9: After reset the local enable and all vote bits are 0, the control word reads 32'h8000_0000, and `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | 1 | Source clock to be gated |
| noc_hs | input | 1 | Network-on-chip handshake state, shown in bit 29 while running |
| reg_wr | input | 1 | Write strobe, one register clock cycle per write |
| reg_addr | input | 1 | Register select: 0 control word, 1 vote word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for the selected word |
| clk_out | output | 1 | Gated branch clock |

## Verification
The bench measures how many register cycles the off flag takes to clear after an enable. A design that skipped the synchroniser would clear it in the very next cycle. A design with a broken crossing would never clear it. After a disable, the bench watches `clk_out` from the moment the flag reads 1, because a status path that tracked the request instead of the gate would report off while edges were still coming out. The bench records the shortest high pulse on the branch clock, which exposes a gate that is registered on the rising edge or left combinational. It also drives a vote on a neighbour's bit, and writes all ones to the read-only status bits, to catch decoding of the wrong vote bit and status bits that software can overwrite.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

    localparam int REG_W = 32;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_VOTE = 1'b1
    } reg_sel_e;

    // Control word layout; the top nibble is decoded by software pollers.
    typedef struct packed {
        logic        off;      // 31
        logic        rsv30;    // 30
        logic        noc_on;   // 29
        logic        rsv28;    // 28
        logic [26:0] rsv_mid;  // 27:1
        logic        enable;   // 0
    } ctrl_word_t;

    function automatic ctrl_word_t pack_ctrl(input logic off,
                                             input logic noc,
                                             input logic en);
        ctrl_word_t w;
        w         = '0;
        w.off     = off;
        w.noc_on  = noc & ~off;
        w.enable  = en;
        return w;
    endfunction

endpackage

// File: rtl/vbg_sync.sv
module vbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/vbg_regs.sv
module vbg_regs
    import vbg_pkg::*;
#(
    parameter int VOTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [REG_W-1:0]  wdata,
    output logic              local_en,
    output logic [VOTE_W-1:0] vote_q
);
    // Bits 31:1 of control writes are dropped on purpose.
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            local_en <= 1'b0;
            vote_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CTRL: local_en <= wdata[0];
                SEL_VOTE: vote_q   <= wdata[VOTE_W-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/vbg_gate.sv
module vbg_gate #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic rst,
    input  logic req,
    output logic gate_q,
    output logic clk_out
);
    logic req_s;

    vbg_sync #(.STAGES(STAGES)) req_sync_i (
        .clk (src_clk),
        .rst (rst),
        .d   (req),
        .q   (req_s)
    );

    // Enable changes only while src_clk is low, so no runt high phase.
    always_ff @(negedge src_clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= req_s;
    end

    assign clk_out = src_clk & gate_q;
endmodule

// File: rtl/vbg_branch_gate.sv
module vbg_branch_gate
    import vbg_pkg::*;
#(
    parameter int VOTE_W      = 8,
    parameter int VOTE_IDX    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        src_clk,
    input  logic        noc_hs,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        clk_out
);
    logic              local_en;
    logic [VOTE_W-1:0] vote_q;
    logic              eff_en;
    logic              gate_q;
    logic              running;
    logic              off_q;
    ctrl_word_t        ctrl_word;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_addr);

    vbg_regs #(.VOTE_W(VOTE_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .local_en (local_en),
        .vote_q   (vote_q)
    );

    // Requests are merged before the crossing: one synchroniser, not two.
    assign eff_en = local_en | vote_q[VOTE_IDX];

    vbg_gate #(.STAGES(SYNC_STAGES)) gate_i (
        .src_clk (src_clk),
        .rst     (rst),
        .req     (eff_en),
        .gate_q  (gate_q),
        .clk_out (clk_out)
    );

    vbg_sync #(.STAGES(SYNC_STAGES)) stat_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (gate_q),
        .q   (running)
    );

    assign off_q     = ~running;
    assign ctrl_word = pack_ctrl(off_q, noc_hs, local_en);

    always_comb begin
        reg_rdata = '0;
        if (sel == SEL_CTRL) reg_rdata = ctrl_word;
        else                 reg_rdata[VOTE_W-1:0] = vote_q;
    end
endmodule

// File: rtl/vbg_branch_gate_chk.sv
module vbg_branch_gate_chk #(
    parameter int VOTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              local_en,
    input logic [VOTE_W-1:0] vote_q,
    input logic              eff_en,
    input logic              off_q,
    input logic [31:0]       ctrl_word
);
    assert_run_code_R4: assert property (@(posedge clk) disable iff (rst)
        !off_q |-> (ctrl_word[31:28] == 4'b0000 || ctrl_word[31:28] == 4'b0010));

    assert_off_code_R5: assert property (@(posedge clk) disable iff (rst)
        off_q |-> ctrl_word[31:28] == 4'b1000);

    assert_local_write_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr) |=> local_en == $past(reg_wdata[0]));

    assert_vote_write_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> vote_q == $past(reg_wdata[VOTE_W-1:0]));

    assert_on_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (eff_en && !off_q) |=> !off_q);

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (!local_en && vote_q == '0));
endmodule

bind vbg_branch_gate vbg_branch_gate_chk #(.VOTE_W(VOTE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .local_en  (local_en),
    .vote_q    (vote_q),
    .eff_en    (eff_en),
    .off_q     (off_q),
    .ctrl_word (ctrl_word)
);

// File: tb/vbg_branch_gate_tb_top.sv
`timescale 1ns/1ps
module vbg_branch_gate_tb_top;
    localparam int VOTE_W   = 8;
    localparam int VOTE_IDX = 3;

    logic        clk = 1'b0;
    logic        src_clk = 1'b0;
    logic        rst = 1'b1;
    logic        noc_hs = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    int edges    = 0;
    realtime t_rise = 0.0;
    realtime min_hi = 1.0e9;
    bit seen_rise = 0;

    always #4 clk = ~clk;                 // 125 MHz register clock
    initial begin
        #1.3;
        forever #3 src_clk = ~src_clk;    // 6 ns source clock
    end

    vbg_branch_gate #(.VOTE_W(VOTE_W), .VOTE_IDX(VOTE_IDX)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_clk   (src_clk),
        .noc_hs    (noc_hs),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk_out   (clk_out)
    );

    always @(posedge clk_out) begin
        edges++;
        t_rise = $realtime;
        seen_rise = 1;
    end
    always @(negedge clk_out) begin
        if (seen_rise && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Write ctrl/vote, then count posedges until off clears (or sets).
    task automatic request(input logic a, input logic [31:0] d,
                           input logic want_off, output int lat);
        logic [31:0] v;
        wr(a, d);
        reg_addr = 1'b0;
        #1 v = reg_rdata;
        if (!want_off) chk(v[31] == 1'b1, "R2 off still set right after write", v, 32'h8000_0000);
        lat = 99;
        for (int n = 1; n <= 20; n++) begin
            @(posedge clk); #1;
            if (reg_rdata[31] == want_off) begin lat = n; break; end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk(v == 32'h8000_0000, "R9 ctrl after reset", v, 32'h8000_0000);
        rd(1'b1, v); chk(v == 32'h0, "R9 vote after reset", v, 32'h0);
        edges = 0;
        repeat (10) @(negedge clk);
        chk(edges == 0 && clk_out == 1'b0, "R9 clk_out quiet after reset", edges, 0);
    endtask

    task automatic t_local_on();
        logic [31:0] v; int lat;
        request(1'b0, 32'h1, 1'b0, lat);
        chk(lat >= 2 && lat <= 10, "R2 off clear latency", lat, 5);
        rd(1'b0, v); chk(v == 32'h0000_0001, "R4 running plain code", v, 32'h1);
        edges = 0; min_hi = 1.0e9;
        repeat (20) @(negedge clk);
        chk(edges > 20, "R1 clk_out toggles when enabled", edges, 26);
        chk(min_hi >= 2.99, "R7 full high pulses", int'(min_hi * 1000), 3000);
        rd(1'b0, v); chk(v[31] == 1'b0, "R2 off stays clear while requested", v, 32'h1);
    endtask

    task automatic t_noc();
        logic [31:0] v;
        @(negedge clk); noc_hs = 1'b1;
        rd(1'b0, v); chk(v[31:28] == 4'b0010, "R5 handshake code while running", v[31:28], 4'b0010);
        @(negedge clk); noc_hs = 1'b0;
        rd(1'b0, v); chk(v[31:28] == 4'b0000, "R4 code after handshake drops", v[31:28], 4'b0000);
    endtask

    task automatic t_ro_write_on();
        logic [31:0] v;
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk(v == 32'h0000_0001, "R8 status bits not writable while on", v, 32'h1);
    endtask

    task automatic t_disable();
        logic [31:0] v; int lat;
        request(1'b0, 32'h0, 1'b1, lat);
        chk(lat <= 10, "R6 off sets after disable", lat, 5);
        edges = 0;
        repeat (12) @(negedge clk);
        chk(edges == 0 && clk_out == 1'b0, "R6 clk_out stopped once off reads 1", edges, 0);
        @(negedge clk); noc_hs = 1'b1;
        rd(1'b0, v); chk(v[31:28] == 4'b1000, "R5 off code ignores handshake", v[31:28], 4'b1000);
        @(negedge clk); noc_hs = 1'b0;
    endtask

    task automatic t_ro_write_off();
        logic [31:0] v;
        wr(1'b0, 32'h7FFF_FFFE);
        rd(1'b0, v); chk(v == 32'h8000_0000, "R8 status bits not writable while off", v, 32'h8000_0000);
        edges = 0;
        repeat (12) @(negedge clk);
        rd(1'b0, v); chk(v[31] && edges == 0, "R8 write to high bits leaves branch off", edges, 0);
    endtask

    task automatic t_vote();
        logic [31:0] v; int lat;
        wr(1'b1, 32'h0000_00F7);                 // every vote bit except VOTE_IDX
        rd(1'b1, v); chk(v == 32'h0000_00F7, "R3 vote readback", v, 32'hF7);
        edges = 0;
        repeat (12) @(negedge clk);
        rd(1'b0, v); chk(v[31] && edges == 0, "R3 other vote bits no effect", edges, 0);
        request(1'b1, 32'h0000_0008, 1'b0, lat);
        chk(lat >= 2 && lat <= 10, "R3 own vote bit turns branch on", lat, 5);
        rd(1'b0, v); chk(v == 32'h0000_0000, "R3 running by vote, local enable 0", v, 32'h0);
        edges = 0;
        repeat (10) @(negedge clk);
        chk(edges > 8, "R3 clk_out toggles under vote", edges, 13);
        request(1'b1, 32'h0, 1'b1, lat);
        chk(lat <= 10, "R3 vote removal turns branch off", lat, 5);
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_local_on();
        t_noc();
        t_ro_write_on();
        t_disable();
        t_ro_write_off();
        t_vote();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule